// File: doc/BRIEF.md
# Secondary Bus Arbiter with External-Arbiter Bypass

This block decides which master owns a secondary parallel bus. Nine external masters each drive an active-low request pin and receive an active-low grant pin. A tenth requester is the bridge's own internal master, which uses an active-high request and grant pair inside the chip. In internal mode the block grants the bus in round-robin order. The grant moves only at safe points: when the bus is idle, or when the current owner drops its request. When nobody is asking, the grant parks on the bridge.

A strap input can hand arbitration to a chip outside the block. When the strap is high, the internal arbiter is held parked. The pin pair at index 0 then changes role. Grant pin 0 carries the bridge's request out to the outside arbiter. Request pin 0 brings that arbiter's grant back in to the bridge. Grant pins 8 to 1 stop driving: their output enables go low. Request pins 8 to 1 are ignored.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While reset is active and just after it is released, in internal mode, the grant is parked on the bridge: own_gnt_o is 1, every gnt_n_o bit is 1 and every gnt_oe_o bit is 1.
- R2: In internal mode, exactly one of the ten grants is asserted in every cycle. The ten grants are gnt_n_o[8:0] low, or own_gnt_o high.
- R3: An external grant gnt_n_o[i] only falls one cycle after a cycle in which req_n_i[i] was low.
- R4: In internal mode, the grant does not change in the next cycle if, in the current cycle, the owner still requests and bus_idle_i is low.
- R5: When the grant may move, the next owner is the first requester after the current owner. The scan runs in increasing index and wraps around. External masters are indices 0 to 8 and the bridge is index 9. The current owner is checked last. The new grant appears one clock after the sampled inputs.
- R6: If the owner withdraws its request, the grant moves at the next clock even when bus_idle_i is low.
- R7: If no requests are present in internal mode, the grant is on the bridge after the next clock.
- R8: In external mode, own_gnt_o equals the inverse of req_n_i[0] in the same cycle, with no clock delay.
- R9: In external mode, gnt_n_o[0] equals the inverse of own_req_i in the same cycle, and gnt_oe_o[0] is 1.
- R10: In external mode, gnt_oe_o[8:1] are 0 and gnt_n_o[8:1] are 1. In internal mode, all nine gnt_oe_o bits are 1.
- R11: In external mode, req_n_i[8:1] have no effect on any output.
- R12: While in external mode, the internal arbiter stays parked on the bridge. In the first cycle after the strap returns low, own_gnt_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_arb_strap_i | input | 1 | 1 selects the external arbiter; 0 selects the internal arbiter |
| bus_idle_i | input | 1 | 1 when no transaction is running on the secondary bus |
| req_n_i | input | 9 | Active-low requests from external masters; in external mode bit 0 is the grant coming in |
| own_req_i | input | 1 | Active-high request from the bridge's internal master |
| gnt_n_o | output | 9 | Active-low grants to external masters; in external mode bit 0 is the request going out |
| gnt_oe_o | output | 9 | Output enable for each grant pin; 0 means the pin floats |
| own_gnt_o | output | 1 | Active-high grant to the bridge's internal master |

## Verification
Some properties are checked by assertions on every clock:
- In internal mode exactly one grant is asserted.
- A new external grant always follows a request.
- The grant holds while a busy bus has a still-requesting owner.
- An empty request set parks the grant on the bridge.
- In external mode the pin roles swap and the output enables follow the mode.
- The grant is parked when the strap falls.

Other behaviour only the bench's scenarios can show:
- The exact round-robin order, including the wrap past the bridge back to index 0.
- The move to the next master when the owner withdraws while the bus is busy.
- That toggling the unused request pins in external mode leaves every output unchanged.

// File: rtl/sec_arb_pkg.sv
package sec_arb_pkg;

    // Number of external request/grant pin pairs.
    parameter int unsigned DEF_EXT_MASTERS = 9;

    typedef enum logic {
        MODE_INTERNAL = 1'b0,
        MODE_EXTERNAL = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/rr_pick.sv
// Rotating-priority picker: returns the first requester after `last`.
// The scan increases in index, wraps around, and checks `last` itself last.
module rr_pick #(
    parameter int unsigned N = 10
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] last,
    output logic [N-1:0] pick,
    output logic         any
);
    int unsigned last_idx;
    int unsigned idx;

    always_comb begin
        // Find the index of the current owner.
        last_idx = 0;
        for (int unsigned i = 0; i < N; i++) begin
            if (last[i]) last_idx = i;
        end

        // Scan from the index after the owner, wrapping around.
        pick = '0;
        any  = 1'b0;
        idx  = 0;
        for (int unsigned k = 1; k <= N; k++) begin
            idx = (last_idx + k) % N;
            if (!any && req[idx]) begin
                pick[idx] = 1'b1;
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_core.sv
// Grant state for the internal arbiter. Index N_ALL-1 is the bridge.
module arb_core #(
    parameter int unsigned N_ALL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode_i,
    input  logic             bus_idle_i,
    input  logic [N_ALL-1:0] req_i,
    output logic [N_ALL-1:0] gnt_o
);
    localparam int unsigned BRIDGE = N_ALL - 1;
    localparam logic [N_ALL-1:0] PARK = {1'b1, {(N_ALL-1){1'b0}}};

    typedef struct packed {
        logic [N_ALL-1:0] gnt;
    } core_state_t;

    core_state_t st_q, st_d;
    logic [N_ALL-1:0] pick;
    logic             pick_any;
    logic             holder_req;
    logic             may_move;

    rr_pick #(.N(N_ALL)) u_pick (
        .req  (req_i),
        .last (st_q.gnt),
        .pick (pick),
        .any  (pick_any)
    );

    always_comb begin
        // The owner still wants the bus.
        holder_req = |(st_q.gnt & req_i);
        // The grant may move at an idle bus or when the owner lets go.
        may_move   = bus_idle_i || !holder_req;
        st_d       = st_q;
        if (ext_mode_i) begin
            st_d.gnt = PARK;
        end else if (may_move) begin
            st_d.gnt = pick_any ? pick : PARK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gnt: PARK};
        else        st_q <= st_d;
    end

    assign gnt_o = st_q.gnt;

    // R3
    for (genvar g = 0; g < N_ALL - 1; g++) begin : g_rise_chk
        grant_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gnt_o[g]) |-> $past(req_i[g]));
    end

    // R4
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && !bus_idle_i && |(gnt_o & req_i)) |=> $stable(gnt_o));

    // R7
    park_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && req_i == '0) |=> gnt_o[BRIDGE]);
endmodule

// File: rtl/pin_mux.sv
// Maps the internal grant state onto the pins, and swaps pin roles in external mode.
module pin_mux
    import sec_arb_pkg::*;
#(
    parameter int unsigned N_EXT = 9
) (
    input  arb_mode_e        mode_i,
    input  logic [N_EXT:0]   core_gnt_i,
    input  logic             own_req_i,
    input  logic [N_EXT-1:0] req_n_i,
    output logic [N_EXT:0]   core_req_o,
    output logic [N_EXT-1:0] gnt_n_o,
    output logic [N_EXT-1:0] gnt_oe_o,
    output logic             own_gnt_o
);
    always_comb begin
        if (mode_i == MODE_EXTERNAL) begin
            // The internal arbiter sees no requests.
            core_req_o  = '0;
            // Unused grant pins float; drive them high anyway.
            gnt_n_o     = '1;
            gnt_n_o[0]  = !own_req_i;   // bridge request goes out on grant pin 0
            gnt_oe_o    = '0;
            gnt_oe_o[0] = 1'b1;
            own_gnt_o   = !req_n_i[0];  // outside grant comes in on request pin 0
        end else begin
            core_req_o  = {own_req_i, ~req_n_i};
            gnt_n_o     = ~core_gnt_i[N_EXT-1:0];
            gnt_oe_o    = '1;
            own_gnt_o   = core_gnt_i[N_EXT];
        end
    end
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
    import sec_arb_pkg::*;
#(
    parameter int unsigned N_EXT = DEF_EXT_MASTERS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_arb_strap_i,
    input  logic             bus_idle_i,
    input  logic [N_EXT-1:0] req_n_i,
    input  logic             own_req_i,
    output logic [N_EXT-1:0] gnt_n_o,
    output logic [N_EXT-1:0] gnt_oe_o,
    output logic             own_gnt_o
);
    localparam int unsigned N_ALL = N_EXT + 1;

    arb_mode_e        mode;
    logic [N_ALL-1:0] core_req;
    logic [N_ALL-1:0] core_gnt;

    assign mode = ext_arb_strap_i ? MODE_EXTERNAL : MODE_INTERNAL;

    arb_core #(.N_ALL(N_ALL)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode_i (ext_arb_strap_i),
        .bus_idle_i (bus_idle_i),
        .req_i      (core_req),
        .gnt_o      (core_gnt)
    );

    pin_mux #(.N_EXT(N_EXT)) u_mux (
        .mode_i     (mode),
        .core_gnt_i (core_gnt),
        .own_req_i  (own_req_i),
        .req_n_i    (req_n_i),
        .core_req_o (core_req),
        .gnt_n_o    (gnt_n_o),
        .gnt_oe_o   (gnt_oe_o),
        .own_gnt_o  (own_gnt_o)
    );

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_arb_strap_i |-> $countones({~gnt_n_o, own_gnt_o}) == 1);

    // R8
    ext_grant_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_arb_strap_i |-> own_gnt_o == !req_n_i[0]);

    // R9
    ext_request_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_arb_strap_i |-> (gnt_n_o[0] == !own_req_i && gnt_oe_o[0]));

    // R10
    oe_by_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_oe_o == (ext_arb_strap_i ? {{(N_EXT-1){1'b0}}, 1'b1} : {N_EXT{1'b1}}));

    // R12
    parked_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_arb_strap_i) |-> own_gnt_o);
endmodule

// File: tb/tb_sec_bus_arbiter.sv
module tb_sec_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0;
    logic       idle = 1'b1;
    logic [8:0] req_n = 9'h1FF;
    logic       own_req = 1'b0;
    logic [8:0] gnt_n;
    logic [8:0] gnt_oe;
    logic       own_gnt;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sec_bus_arbiter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ext_arb_strap_i (ext),
        .bus_idle_i      (idle),
        .req_n_i         (req_n),
        .own_req_i       (own_req),
        .gnt_n_o         (gnt_n),
        .gnt_oe_o        (gnt_oe),
        .own_gnt_o       (own_gnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Each entry: {request mask (active high), own_req, idle, expected gnt_n, expected own_gnt}
    localparam int NV = 11;
    localparam logic [20:0] VEC [NV] = '{
        {9'h000, 1'b0, 1'b1, 9'h1FF, 1'b1}, // R7 parked with nothing pending
        {9'h008, 1'b0, 1'b0, 9'h1F7, 1'b1 ^ 1'b1}, // R5 move off the parked bridge to 3
        {9'h028, 1'b0, 1'b0, 9'h1F7, 1'b0}, // R4 hold while busy
        {9'h028, 1'b0, 1'b1, 9'h1DF, 1'b0}, // R5 idle: 3 -> 5
        {9'h028, 1'b1, 1'b1, 9'h1FF, 1'b1}, // R5 5 -> bridge
        {9'h028, 1'b1, 1'b1, 9'h1F7, 1'b0}, // R5 bridge wraps to 3
        {9'h020, 1'b1, 1'b0, 9'h1DF, 1'b0}, // R6 withdrawal moves to 5 while busy
        {9'h000, 1'b0, 1'b0, 9'h1FF, 1'b1}, // R7 owner leaves with no other requests
        {9'h101, 1'b0, 1'b1, 9'h1FE, 1'b0}, // R5 bridge -> 0
        {9'h101, 1'b0, 1'b1, 9'h0FF, 1'b0}, // R5 0 -> 8
        {9'h101, 1'b0, 1'b1, 9'h1FE, 1'b0}  // R5 8 wraps past the bridge to 0
    };

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Check outputs while reset is held (R1).
        repeat (2) @(negedge clk);
        check("R1 reset own_gnt", 32'(own_gnt), 32'd1);
        check("R1 reset gnt_n", 32'(gnt_n), 32'h1FF);
        check("R1 reset gnt_oe", 32'(gnt_oe), 32'h1FF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release own_gnt", 32'(own_gnt), 32'd1);

        // Walk the vector table: drive at a falling edge, check at the next one.
        for (int i = 0; i < NV; i++) begin
            req_n   = ~VEC[i][20:12];
            own_req = VEC[i][11];
            idle    = VEC[i][10];
            @(negedge clk);
            check($sformatf("R5 vec%0d gnt_n", i), 32'(gnt_n), 32'(VEC[i][9:1]));
            check($sformatf("R2 vec%0d own_gnt", i), 32'(own_gnt), 32'(VEC[i][0]));
        end

        // R3: a master that never requests is never granted.
        req_n = 9'h1FF; own_req = 1'b0; idle = 1'b1;
        @(negedge clk);
        check("R3 no request no grant", 32'(gnt_n), 32'h1FF);

        // External mode: outputs follow the inputs with no clock delay.
        ext = 1'b1; own_req = 1'b1; req_n = 9'h1FF;
        #1;
        check("R10 ext oe", 32'(gnt_oe), 32'h001);
        check("R10 ext unused grants high", 32'(gnt_n[8:1]), 32'hFF);
        check("R9 ext request out", 32'(gnt_n[0]), 32'd0);
        check("R8 ext no grant in", 32'(own_gnt), 32'd0);
        req_n[0] = 1'b0;
        #1;
        check("R8 ext grant in", 32'(own_gnt), 32'd1);
        own_req = 1'b0;
        #1;
        check("R9 ext request dropped", 32'(gnt_n[0]), 32'd1);

        // R11: toggling the unused request pins changes nothing.
        req_n[8:1] = 8'h00;
        @(negedge clk);
        check("R11 ignore req gnt_n", 32'(gnt_n), 32'h1FF);
        check("R11 ignore req oe", 32'(gnt_oe), 32'h001);
        check("R11 ignore req own_gnt", 32'(own_gnt), 32'd1);
        req_n[8:1] = 8'hAA;
        @(negedge clk);
        check("R11 ignore req pattern", 32'({gnt_n, gnt_oe, own_gnt}), 32'({9'h1FF, 9'h001, 1'b1}));

        // R12: back to internal mode, still parked on the bridge.
        req_n = 9'h1FF; own_req = 1'b0; ext = 1'b0;
        #1;
        check("R12 parked on return", 32'(own_gnt), 32'd1);
        check("R10 internal oe", 32'(gnt_oe), 32'h1FF);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule